// File: doc/BRIEF.md
# Programmable Interlaced Sync Generator

This block generates the composite sync, composite blank, horizontal drive, vertical drive, field and vertical interrupt timing for interlaced video. A horizontal counter steps once for each enabled clock. A vertical counter steps once for each half-line, so a field of N half-lines with N odd gives interlace with no extra logic. Every edge of every output comes from a 12-bit end-time or window value in a configuration word. During the pulse interval of the vertical blank, composite sync switches from the normal line sync to equalisation pulses at half-line rate. Inside the vertical sync interval it switches again, to wide serration pulses.

The configuration is loaded as one parallel bus into a shadow store. A restart input freezes the outputs and parks the counters at position 1 of the odd field. A clear input freezes the outputs and zeroes the configuration and the counters. Operation resumes at the first enabled clock after the input is released. This lets an external timing reference gen-lock the generator to the start of the odd field. Counting runs only while the run bit of the mode word is set. A parameter selects whether that bit comes out of reset set or cleared.

Top module: `isync_gen`

## Requirements
- R1: Synchronous active-high `rst` drives every output high (inactive), parks the counters at horizontal 1, half-line 1, odd field, and loads the default configuration.
- R2: A clock is enabled only when bit 10 of the mode word is 1 and neither `restart_req` nor `clear_req` is high. With `RUN_AT_RESET`=0 that bit resets to 0. On any cycle that is not enabled, all six outputs hold their values.
- R3: The horizontal position runs from 1 to `line_len`, then returns to 1. Outputs are registered: each enabled edge presents the decode of the position held before that edge.
- R4: The horizontal sync window is `hfp_end` <= h < `hsync_end`. The horizontal blank window is h < `hblank_end`.
- R5: The half-line boundaries are h == `line_len`/2 (rounded down) and h == `line_len`. At each boundary the half-line count v steps, running 1 to `field_len`. At the wrap the field flag toggles. `field_odd_n` is low in the odd field.
- R6: The vertical blank window is v < `vblank_end`. `cblank_n` is low in the union of the horizontal and vertical blank windows.
- R7: While `pint_start` <= v < `pint_end`, composite sync uses hh, the position within the current half-line. Inside `vfp_end` <= v < `vsync_end` it is low for `hfp_end` <= hh < `serr_start` (serration). Elsewhere in that range it is low for `hfp_end` <= hh < `eq_end` (equalisation). Outside that range it equals horizontal sync.
- R8: Horizontal drive, vertical drive and vertical interrupt are windows [start, end) on h, v and v. When start > end the window wraps: x >= start or x < end. When start == end the window is empty.
- R9: While `restart_req` is high the counters are held at h=1, v=1, odd field. The first enabled edge after release outputs the decode of that position.
- R10: While `clear_req` is high the configuration and the counters are zero. Clear takes priority over load and restart.
- R11: On an edge with `cfg_load` high, the store takes `cfg_bus`. From MSB down, the bus carries 19 fields of 12 bits each, in this order: mode, line_len, field_len, hfp_end, hsync_end, hblank_end, vfp_end, vsync_end, vblank_end, eq_end, serr_start, pint_start, pint_end, hdrv_start, hdrv_end, vdrv_start, vdrv_end, vint_start, vint_end.
- R12: The defaults, in that same order, are: mode 1024 when `RUN_AT_RESET`=1 and 0 otherwise, then 910, 525, 23, 91, 157, 7, 13, 41, 57, 410, 1, 19, 911, 92, 1, 21, 41, 526.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| restart_req | input | 1 | Hold high to freeze and park at odd-field start |
| clear_req | input | 1 | Hold high to freeze and zero configuration and counters |
| cfg_load | input | 1 | Load `cfg_bus` into the configuration store |
| cfg_bus | input | 228 | Packed configuration, field order as in R11 |
| csync_n | output | 1 | Composite sync, active low |
| cblank_n | output | 1 | Composite blank, active low |
| hdrive_n | output | 1 | Horizontal drive, active low |
| vdrive_n | output | 1 | Vertical drive, active low |
| field_odd_n | output | 1 | Low during the odd field |
| vint_n | output | 1 | Vertical interrupt window, active low |

## Verification
Each output is due one edge after the enabled edge that consumes a counter position. The bench therefore models the position and the configuration as they stand before each edge, computes the expected levels for that edge, and compares them at the following falling edge. Restart, clear and a run bit of zero take effect on the same edge they are presented. A load changes the decode only from the edge after it, because the decode on the load edge still uses the old configuration. The model applies each of these in that order. A second instance starts running from reset, so its first lines can be checked against the default timing.

// File: rtl/sg_pkg.sv
package sg_pkg;
  localparam int SG_W       = 12;
  localparam int SG_NREG    = 19;
  localparam int SG_RUN_BIT = 10;

  typedef logic [SG_W-1:0] sg_word_t;

  typedef struct packed {
    sg_word_t mode, line_len, field_len;
    sg_word_t hfp_end, hsync_end, hblank_end;
    sg_word_t vfp_end, vsync_end, vblank_end;
    sg_word_t eq_end, serr_start, pint_start, pint_end;
    sg_word_t hdrv_start, hdrv_end, vdrv_start, vdrv_end;
    sg_word_t vint_start, vint_end;
  } sg_cfg_t;

  localparam int SG_CFG_BITS = $bits(sg_cfg_t);

  function automatic sg_cfg_t sg_defaults(input logic run);
    sg_cfg_t d;
    d = '0;
    d.mode[SG_RUN_BIT] = run;
    d.line_len   = SG_W'(910);
    d.field_len  = SG_W'(525);
    d.hfp_end    = SG_W'(23);
    d.hsync_end  = SG_W'(91);
    d.hblank_end = SG_W'(157);
    d.vfp_end    = SG_W'(7);
    d.vsync_end  = SG_W'(13);
    d.vblank_end = SG_W'(41);
    d.eq_end     = SG_W'(57);
    d.serr_start = SG_W'(410);
    d.pint_start = SG_W'(1);
    d.pint_end   = SG_W'(19);
    d.hdrv_start = SG_W'(911);
    d.hdrv_end   = SG_W'(92);
    d.vdrv_start = SG_W'(1);
    d.vdrv_end   = SG_W'(21);
    d.vint_start = SG_W'(41);
    d.vint_end   = SG_W'(526);
    return d;
  endfunction

  // [s,e) window; wraps when s > e; empty when s == e
  function automatic logic sg_in_window(input sg_word_t x, input sg_word_t s,
                                        input sg_word_t e);
    return (s <= e) ? (x >= s && x < e) : (x >= s || x < e);
  endfunction
endpackage

// File: rtl/sg_cfg_store.sv
module sg_cfg_store import sg_pkg::*; #(
  parameter bit RUN_AT_RESET = 1'b0
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   clear_req,
  input  logic                   cfg_load,
  input  logic [SG_CFG_BITS-1:0] cfg_bus,
  output sg_cfg_t                cfg
);
  always_ff @(posedge clk) begin
    if (rst)            cfg <= sg_defaults(RUN_AT_RESET);
    else if (clear_req) cfg <= '0;
    else if (cfg_load)  cfg <= sg_cfg_t'(cfg_bus);
  end

  // R10
  cfg_clear_chk: assert property (@(posedge clk) disable iff (rst)
    clear_req |=> (cfg == '0));

  // R11
  cfg_load_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_load && !clear_req) |=> (cfg == sg_cfg_t'($past(cfg_bus))));
endmodule

// File: rtl/sg_timebase.sv
module sg_timebase import sg_pkg::*; (
  input  logic     clk,
  input  logic     rst,
  input  logic     en,
  input  logic     restart_req,
  input  logic     clear_req,
  input  sg_word_t line_len,
  input  sg_word_t field_len,
  output sg_word_t h_pos,
  output sg_word_t v_pos,
  output logic     fld
);
  sg_word_t half_len;
  logic     line_end, hl_end, field_wrap;

  assign half_len   = line_len >> 1;
  assign line_end   = (h_pos >= line_len);
  assign hl_end     = line_end || (h_pos == half_len);
  assign field_wrap = (v_pos >= field_len);

  always_ff @(posedge clk) begin
    if (rst) begin
      h_pos <= SG_W'(1);
      v_pos <= SG_W'(1);
      fld   <= 1'b0;
    end else if (clear_req) begin
      h_pos <= '0;
      v_pos <= '0;
      fld   <= 1'b0;
    end else if (restart_req) begin
      h_pos <= SG_W'(1);
      v_pos <= SG_W'(1);
      fld   <= 1'b0;
    end else if (en) begin
      h_pos <= line_end ? SG_W'(1) : h_pos + SG_W'(1);
      if (hl_end) begin
        v_pos <= field_wrap ? SG_W'(1) : v_pos + SG_W'(1);
        if (field_wrap) fld <= ~fld;
      end
    end
  end

  // R3
  h_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (en && h_pos >= line_len) |=> (h_pos == SG_W'(1)));

  // R2
  tb_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!en && !restart_req && !clear_req) |=> ($stable(h_pos) && $stable(v_pos) && $stable(fld)));

  // R9
  restart_park_chk: assert property (@(posedge clk) disable iff (rst)
    (restart_req && !clear_req) |=> (h_pos == SG_W'(1) && v_pos == SG_W'(1) && !fld));

  // R10
  clear_cnt_chk: assert property (@(posedge clk) disable iff (rst)
    clear_req |=> (h_pos == '0 && v_pos == '0));

  // R5
  field_flip_chk: assert property (@(posedge clk) disable iff (rst)
    (en && hl_end && v_pos >= field_len) |=> (fld != $past(fld)));
endmodule

// File: rtl/sg_decode.sv
module sg_decode import sg_pkg::*; (
  input  logic     clk,
  input  logic     rst,
  input  logic     en,
  input  sg_cfg_t  cfg,
  input  sg_word_t h_pos,
  input  sg_word_t v_pos,
  input  logic     fld,
  output logic     csync_n,
  output logic     cblank_n,
  output logic     hdrive_n,
  output logic     vdrive_n,
  output logic     field_odd_n,
  output logic     vint_n
);
  sg_word_t half_len, hh;
  logic hsync, hblank, vblank, vsync_iv, pint, eq_pulse, serr_pulse;
  logic csync, hdrv, vdrv, vint;
  logic unused_cfg_bits;

  assign unused_cfg_bits = ^{cfg.mode, cfg.field_len};

  assign half_len = cfg.line_len >> 1;
  assign hh       = (h_pos > half_len) ? h_pos - half_len : h_pos;

  assign hsync      = (h_pos >= cfg.hfp_end) && (h_pos < cfg.hsync_end);
  assign hblank     = (h_pos < cfg.hblank_end);
  assign vblank     = (v_pos < cfg.vblank_end);
  assign vsync_iv   = (v_pos >= cfg.vfp_end) && (v_pos < cfg.vsync_end);
  assign pint       = (v_pos >= cfg.pint_start) && (v_pos < cfg.pint_end);
  assign eq_pulse   = (hh >= cfg.hfp_end) && (hh < cfg.eq_end);
  assign serr_pulse = (hh >= cfg.hfp_end) && (hh < cfg.serr_start);

  always_comb begin
    if (pint) csync = vsync_iv ? serr_pulse : eq_pulse;
    else      csync = hsync;
  end

  assign hdrv = sg_in_window(h_pos, cfg.hdrv_start, cfg.hdrv_end);
  assign vdrv = sg_in_window(v_pos, cfg.vdrv_start, cfg.vdrv_end);
  assign vint = sg_in_window(v_pos, cfg.vint_start, cfg.vint_end);

  always_ff @(posedge clk) begin
    if (rst) begin
      csync_n     <= 1'b1;
      cblank_n    <= 1'b1;
      hdrive_n    <= 1'b1;
      vdrive_n    <= 1'b1;
      field_odd_n <= 1'b1;
      vint_n      <= 1'b1;
    end else if (en) begin
      csync_n     <= ~csync;
      cblank_n    <= ~(hblank | vblank);
      hdrive_n    <= ~hdrv;
      vdrive_n    <= ~vdrv;
      field_odd_n <= fld;
      vint_n      <= ~vint;
    end
  end

  // R2
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable({csync_n, cblank_n, hdrive_n, vdrive_n, field_odd_n, vint_n}));
endmodule

// File: rtl/isync_gen.sv
module isync_gen import sg_pkg::*; #(
  parameter bit RUN_AT_RESET = 1'b0
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   restart_req,
  input  logic                   clear_req,
  input  logic                   cfg_load,
  input  logic [SG_CFG_BITS-1:0] cfg_bus,
  output logic                   csync_n,
  output logic                   cblank_n,
  output logic                   hdrive_n,
  output logic                   vdrive_n,
  output logic                   field_odd_n,
  output logic                   vint_n
);
  sg_cfg_t  cfg;
  sg_word_t h_pos, v_pos;
  logic     fld, en;

  assign en = cfg.mode[SG_RUN_BIT] & ~restart_req & ~clear_req;

  sg_cfg_store #(.RUN_AT_RESET(RUN_AT_RESET)) u_store (
    .clk(clk), .rst(rst), .clear_req(clear_req), .cfg_load(cfg_load),
    .cfg_bus(cfg_bus), .cfg(cfg)
  );

  sg_timebase u_tb (
    .clk(clk), .rst(rst), .en(en), .restart_req(restart_req),
    .clear_req(clear_req), .line_len(cfg.line_len), .field_len(cfg.field_len),
    .h_pos(h_pos), .v_pos(v_pos), .fld(fld)
  );

  sg_decode u_dec (
    .clk(clk), .rst(rst), .en(en), .cfg(cfg), .h_pos(h_pos), .v_pos(v_pos),
    .fld(fld), .csync_n(csync_n), .cblank_n(cblank_n), .hdrive_n(hdrive_n),
    .vdrive_n(vdrive_n), .field_odd_n(field_odd_n), .vint_n(vint_n)
  );
endmodule

// File: tb/tb_isync_gen.sv
`timescale 1ns/1ps
module tb_isync_gen;
  localparam int NF = 19;
  localparam int BW = NF * 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic restart_req = 1'b0, clear_req = 1'b0, cfg_load = 1'b0;
  logic [BW-1:0] cfg_bus = '0;
  logic [5:0] o_m, o_d;

  always #5 clk = ~clk;

  isync_gen #(.RUN_AT_RESET(1'b0)) dut (
    .clk(clk), .rst(rst), .restart_req(restart_req), .clear_req(clear_req),
    .cfg_load(cfg_load), .cfg_bus(cfg_bus),
    .csync_n(o_m[5]), .cblank_n(o_m[4]), .hdrive_n(o_m[3]),
    .vdrive_n(o_m[2]), .field_odd_n(o_m[1]), .vint_n(o_m[0])
  );

  isync_gen #(.RUN_AT_RESET(1'b1)) dut_dflt (
    .clk(clk), .rst(rst), .restart_req(1'b0), .clear_req(1'b0),
    .cfg_load(1'b0), .cfg_bus('0),
    .csync_n(o_d[5]), .cblank_n(o_d[4]), .hdrive_n(o_d[3]),
    .vdrive_n(o_d[2]), .field_odd_n(o_d[1]), .vint_n(o_d[0])
  );

  int vectors = 0, errors = 0;
  int cm[NF], nc[NF], dc[NF];
  int mh, mv, mf, dh, dv, df;
  logic [5:0] mexp, dexp;
  bit done = 0;

  // field order of R11; values of R12
  int dflt_vals[NF] = '{1024, 910, 525, 23, 91, 157, 7, 13, 41, 57, 410, 1, 19,
                        911, 92, 1, 21, 41, 526};
  int cfg_a[NF] = '{1024, 20, 21, 3, 6, 8, 3, 5, 9, 5, 8, 1, 7, 21, 7, 2, 6, 9, 22};
  int cfg_b[NF] = '{1024, 16, 15, 2, 5, 7, 2, 4, 7, 4, 6, 1, 6, 4, 9, 13, 3, 5, 5};

  function automatic bit win(int x, int s, int e);
    return (s <= e) ? (x >= s && x < e) : (x >= s || x < e);
  endfunction

  function automatic logic [5:0] dec(int c[NF], int h, int v, int f);
    int half, hh;
    bit hs, hb, vb, vs, pi, eq, se, cs;
    half = c[1] / 2;
    hh = (h > half) ? h - half : h;
    hs = (h >= c[3]) && (h < c[4]);
    hb = h < c[5];
    vb = v < c[8];
    vs = (v >= c[6]) && (v < c[7]);
    pi = (v >= c[11]) && (v < c[12]);
    eq = (hh >= c[3]) && (hh < c[9]);
    se = (hh >= c[3]) && (hh < c[10]);
    cs = pi ? (vs ? se : eq) : hs;
    return ~{cs, hb | vb, win(h, c[13], c[14]), win(v, c[15], c[16]),
             (f == 0), win(v, c[17], c[18])};
  endfunction

  task automatic adv(input int c[NF], inout int h, inout int v, inout int f);
    int half;
    bit hl;
    half = c[1] / 2;
    hl = (h == half) || (h >= c[1]);
    if (hl) begin
      if (v >= c[2]) begin v = 1; f = f ^ 1; end
      else v = v + 1;
    end
    h = (h >= c[1]) ? 1 : h + 1;
  endtask

  task automatic put_bus(input int c[NF]);
    for (int k = 0; k < NF; k++) begin
      cfg_bus[(NF-1-k)*12 +: 12] = 12'(c[k]);
      nc[k] = c[k];
    end
  endtask

  task automatic cmp(input logic [5:0] got, input logic [5:0] exp, input string tag);
    string nm[6] = '{"vint_n R8", "field_odd_n R5", "vdrive_n R8", "hdrive_n R8",
                     "cblank_n R6", "csync_n R4/R7"};
    vectors++;
    for (int b = 0; b < 6; b++)
      if (got[b] !== exp[b]) begin
        errors++;
        $display("FAIL %s [%s] t=%0t actual=%b expected=%b", nm[b], tag, $time, got[b], exp[b]);
      end
  endtask

  // one edge: model state before edge -> expected after edge
  task automatic cyc(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      if (((cm[0] >> 10) & 1) == 1 && !restart_req && !clear_req) begin
        mexp = dec(cm, mh, mv, mf);
        adv(cm, mh, mv, mf);
      end
      if (clear_req) begin mh = 0; mv = 0; mf = 0; end
      else if (restart_req) begin mh = 1; mv = 1; mf = 0; end
      if (clear_req) for (int k = 0; k < NF; k++) cm[k] = 0;
      else if (cfg_load) cm = nc;
      dexp = dec(dc, dh, dv, df);
      adv(dc, dh, dv, df);
      @(negedge clk);
      cmp(o_m, mexp, tag);
      cmp(o_d, dexp, "R12 default timing");
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    cm = dflt_vals; cm[0] = 0;
    dc = dflt_vals;
    mh = 1; mv = 1; mf = 0; dh = 1; dv = 1; df = 0;
    mexp = 6'h3f; dexp = 6'h3f;
    repeat (3) @(negedge clk);
    cmp(o_m, 6'h3f, "R1 reset outputs");
    cmp(o_d, 6'h3f, "R1 reset outputs");
    rst = 1'b0;
    cyc(6, "R1/R2 idle after reset, run bit 0");

    put_bus(cfg_a); cfg_load = 1'b1;
    cyc(1, "R11 load A");
    cfg_load = 1'b0;
    cyc(900, "R3/R5 sweep A");

    restart_req = 1'b1;
    cyc(7, "R9 restart held");
    restart_req = 1'b0;
    cyc(300, "R9 resume at odd start");

    cfg_a[0] = 0; put_bus(cfg_a); cfg_load = 1'b1;
    cyc(1, "R11 load run off");
    cfg_load = 1'b0;
    cyc(20, "R2 run bit clear holds");
    cfg_a[0] = 1024; put_bus(cfg_a); cfg_load = 1'b1;
    cyc(1, "R11 reload A");
    cfg_load = 1'b0;
    cyc(50, "R3 continue A");

    clear_req = 1'b1; cfg_load = 1'b1;
    cyc(4, "R10 clear held over load");
    clear_req = 1'b0; cfg_load = 1'b0;
    cyc(10, "R10 after clear frozen");

    put_bus(cfg_b); cfg_load = 1'b1;
    cyc(1, "R11 load B");
    cfg_load = 1'b0; restart_req = 1'b1;
    cyc(1, "R9 restart pulse");
    restart_req = 1'b0;
    cyc(500, "R8 sweep B wrap and empty windows");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule